// File: doc/BRIEF.md
# Reference Clock Phase-Comparison Pre-Divider

This block sits in front of a DPLL phase detector and turns one of several reference clocks into the comparison strobe that the detector consumes. Each reference passes through its own two-flop synchroniser and edge detector in the fast system clock domain. A selector then picks one reference. The selected reference's configuration byte sets how many active edges make up one comparison period.

Three modes exist for each reference. In pass-through, every active edge produces a strobe. In the automatic 8 kHz mode, the divide ratio is looked up from a spot-frequency code and the network type. In the manual mode, the ratio is N+1, and a single global N is shared by every reference that selects this mode. N is written as a low byte followed by a high byte. Values outside the legal range are clamped, and a sticky flag records the clamp. The active edge (rising or falling) can be chosen and is reported on a pin. Any change to the effective configuration restarts the edge count.

Top module: `refclk_prediv`

## Requirements
- R1: In pass-through mode (config bit 7 = 0, bit 6 = 0), one strobe follows every active edge of the selected reference. A select value at or above the number of references produces no strobe at all.
- R2: Automatic mode (bit 7 = 0, bit 6 = 1) divides by a ratio taken from spot code bits [3:0]:
  - code 0 gives 1.
  - code 1 gives 8.
  - code 2 gives 193 when the network type is 1 and 256 when it is 0.
  - code 3 gives 810.
  - code 4 gives 2430.
- R3: Manual mode (bit 7 = 1) divides by N+1 whatever bit 6 holds, and all references in this mode use the same N.
- R4: A write to address NUM_REFS stages the low byte of N. A write to address NUM_REFS+1 commits {data, staged low byte} as N. A committed value below 1 or above N_MAX is clamped to the nearer limit and sets n_clamp_err_o, which stays set until reset.
- R5: In automatic mode, spot codes 5 to 15 fall back to pass-through, and unsupported_o is 1 while such a reference is selected.
- R6: Bit 0 of the control register at address NUM_REFS+2 chooses the active edge: 0 for rising, 1 for falling. edge_pol_o shows the current choice.
- R7: Bit 1 of the control register holds the network type. Its reset value is taken from net_type_pin_i.
- R8: Any change of select, mode, ratio or edge choice clears the edge count, so the first strobe after the change comes after a full ratio of active edges.
- R9: After reset the outputs are as follows:
  - cmp_strobe_o, edge_pol_o, unsupported_o and n_clamp_err_o are all 0.
  - Every reference is in pass-through.
  - N is 1.
- R10: cmp_strobe_o is high for exactly one system clock per period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ref_i | input | NUM_REFS | Reference clocks, asynchronous |
| ref_sel_i | input | SEL_W | Index of the reference that feeds the divider |
| net_type_pin_i | input | 1 | Reset value of the network type bit |
| wr_en_i | input | 1 | Configuration write strobe |
| wr_addr_i | input | ADDR_W | Configuration write address |
| wr_data_i | input | 8 | Configuration write data |
| cmp_strobe_o | output | 1 | Single-cycle comparison strobe |
| edge_pol_o | output | 1 | Active edge in use, 1 = falling |
| unsupported_o | output | 1 | Selected automatic-mode spot code is not supported |
| n_clamp_err_o | output | 1 | Sticky flag for a clamped N write |

## Verification
The bench builds the block with NUM_REFS = 3 and N_MAX = 99. With three references on a two-bit select, the out-of-range select value 3 can be driven. A limit of 99 lets an upper clamp be shown through a 100-edge period in a few hundred reference cycles. The automatic table (including the 193 and 256 ratios that depend on network type), manual priority over automatic, the restart on reconfiguration and falling-edge locking are all observed through the strobe timing alone.

// File: rtl/prediv_pkg.sv
package prediv_pkg;

  typedef enum logic [1:0] {
    MODE_PASS   = 2'd0,
    MODE_AUTO   = 2'd1,
    MODE_MANUAL = 2'd2
  } prediv_mode_e;

  // largest ratio the automatic table can produce
  localparam int unsigned AUTO_RATIO_MAX = 2430;

  typedef struct packed {
    logic        valid;
    logic [15:0] ratio;
  } spot_ratio_t;

  // spot code to divide ratio that brings the reference down to 8 kHz
  function automatic spot_ratio_t spot_lookup(input logic [3:0] code, input logic sonet);
    spot_ratio_t r;
    r.valid = 1'b1;
    case (code)
      4'd0:    r.ratio = 16'd1;
      4'd1:    r.ratio = 16'd8;
      4'd2:    r.ratio = sonet ? 16'd193 : 16'd256;
      4'd3:    r.ratio = 16'd810;
      4'd4:    r.ratio = 16'd2430;
      default: begin
        r.valid = 1'b0;
        r.ratio = 16'd1;
      end
    endcase
    return r;
  endfunction

endpackage

// File: rtl/prediv_sync_edge.sv
module prediv_sync_edge (
  input  logic clk,
  input  logic rst,
  input  logic ref_async,
  output logic rise_o,
  output logic fall_o
);

  logic meta_q, stab_q, last_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta_q <= 1'b0;
      stab_q <= 1'b0;
      last_q <= 1'b0;
    end else begin
      meta_q <= ref_async;
      stab_q <= meta_q;
      last_q <= stab_q;
    end
  end

  assign rise_o = stab_q & ~last_q;
  assign fall_o = ~stab_q & last_q;

endmodule

// File: rtl/prediv_cfg_regs.sv
module prediv_cfg_regs #(
  parameter int NUM_REFS = 4,
  parameter int N_MAX    = 12499,
  localparam int ADDR_W  = $clog2(NUM_REFS + 3),
  localparam int N_W     = $clog2(N_MAX + 1)
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  net_type_pin_i,
  input  logic                  wr_en_i,
  input  logic [ADDR_W-1:0]     wr_addr_i,
  input  logic [7:0]            wr_data_i,
  output logic [NUM_REFS*8-1:0] cfg_flat_o,
  output logic [N_W-1:0]        n_o,
  output logic                  falling_o,
  output logic                  sonet_o,
  output logic                  clamp_err_o
);

  localparam int A_NLO  = NUM_REFS;
  localparam int A_NHI  = NUM_REFS + 1;
  localparam int A_CTRL = NUM_REFS + 2;

  logic [7:0]     cfg_q [NUM_REFS];
  logic [7:0]     nlo_q;
  logic [N_W-1:0] n_q;
  logic           fall_q, sonet_q, err_q;
  logic [15:0]    n_full;

  assign n_full = {wr_data_i, nlo_q};

  generate
    for (genvar g = 0; g < NUM_REFS; g++) begin : g_cfg
      always_ff @(posedge clk) begin
        if (rst)
          cfg_q[g] <= 8'h00;
        else if (wr_en_i && int'(wr_addr_i) == g)
          cfg_q[g] <= wr_data_i;
      end
      assign cfg_flat_o[g*8 +: 8] = cfg_q[g];
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      nlo_q   <= 8'h00;
      n_q     <= N_W'(1);
      fall_q  <= 1'b0;
      sonet_q <= net_type_pin_i;
      err_q   <= 1'b0;
    end else if (wr_en_i) begin
      if (int'(wr_addr_i) == A_NLO)
        nlo_q <= wr_data_i;
      if (int'(wr_addr_i) == A_NHI) begin
        if (n_full == 16'd0) begin
          n_q   <= N_W'(1);
          err_q <= 1'b1;
        end else if (int'(n_full) > N_MAX) begin
          n_q   <= N_W'(N_MAX);
          err_q <= 1'b1;
        end else begin
          n_q <= N_W'(n_full);
        end
      end
      if (int'(wr_addr_i) == A_CTRL) begin
        fall_q  <= wr_data_i[0];
        sonet_q <= wr_data_i[1];
      end
    end
  end

  assign n_o         = n_q;
  assign falling_o   = fall_q;
  assign sonet_o     = sonet_q;
  assign clamp_err_o = err_q;

  // R4: committed N always inside the legal window
  assert_n_in_range_R4: assert property (@(posedge clk) disable iff (rst)
    (int'(n_q) >= 1) && (int'(n_q) <= N_MAX));

  // R4: clamp flag is sticky
  assert_err_sticky_R4: assert property (@(posedge clk) disable iff (rst)
    err_q |=> err_q);

endmodule

// File: rtl/prediv_ratio_sel.sv
module prediv_ratio_sel
  import prediv_pkg::*;
#(
  parameter int N_MAX    = 12499,
  localparam int N_W     = $clog2(N_MAX + 1),
  localparam int RMAX    = ((N_MAX + 1) > int'(AUTO_RATIO_MAX)) ? (N_MAX + 1) : int'(AUTO_RATIO_MAX),
  localparam int RATIO_W = $clog2(RMAX + 1)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [7:0]         cfg_i,
  input  logic [N_W-1:0]     n_i,
  input  logic               sonet_i,
  output prediv_mode_e       mode_o,
  output logic [RATIO_W-1:0] ratio_o,
  output logic               unsupported_o
);

  spot_ratio_t spot;

  always_comb begin
    spot          = spot_lookup(cfg_i[3:0], sonet_i);
    unsupported_o = 1'b0;
    if (cfg_i[7]) begin
      mode_o  = MODE_MANUAL;
      ratio_o = RATIO_W'(n_i) + RATIO_W'(1);
    end else if (cfg_i[6]) begin
      mode_o = MODE_AUTO;
      if (spot.valid) begin
        ratio_o = RATIO_W'(spot.ratio);
      end else begin
        ratio_o       = RATIO_W'(1);
        unsupported_o = 1'b1;
      end
    end else begin
      mode_o  = MODE_PASS;
      ratio_o = RATIO_W'(1);
    end
  end

  // R5: unsupported spot code always falls back to a ratio of one
  assert_bypass_on_bad_code_R5: assert property (@(posedge clk) disable iff (rst)
    unsupported_o |-> (ratio_o == RATIO_W'(1)));

  // R3: manual mode ratio is never below two
  assert_manual_ratio_R3: assert property (@(posedge clk) disable iff (rst)
    (mode_o == MODE_MANUAL) |-> (ratio_o >= RATIO_W'(2)));

endmodule

// File: rtl/prediv_counter.sv
module prediv_counter #(
  parameter int RATIO_W = 14,
  parameter int SIG_W   = 20
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               event_i,
  input  logic [RATIO_W-1:0] ratio_i,
  input  logic [SIG_W-1:0]   sig_i,
  output logic               strobe_o
);

  logic [RATIO_W-1:0] cnt_q;
  logic [SIG_W-1:0]   sig_q;
  logic               changed;
  logic               last;
  logic               strobe_q;

  assign changed = (sig_i != sig_q);
  assign last    = (cnt_q == ratio_i - RATIO_W'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q    <= '0;
      sig_q    <= '0;
      strobe_q <= 1'b0;
    end else begin
      sig_q    <= sig_i;
      strobe_q <= 1'b0;
      if (changed) begin
        cnt_q <= '0;
      end else if (event_i) begin
        if (last) begin
          cnt_q    <= '0;
          strobe_q <= 1'b1;
        end else begin
          cnt_q <= cnt_q + RATIO_W'(1);
        end
      end
    end
  end

  assign strobe_o = strobe_q;

  // R8: a configuration change restarts the count
  assert_restart_on_change_R8: assert property (@(posedge clk) disable iff (rst)
    changed |=> (cnt_q == '0));

  // R3: with stable configuration the count stays below the ratio
  assert_cnt_below_ratio_R3: assert property (@(posedge clk) disable iff (rst)
    !changed |-> (cnt_q < ratio_i));

  // R10: strobe never lasts two cycles
  assert_strobe_single_R10: assert property (@(posedge clk) disable iff (rst)
    strobe_q |=> !strobe_q);

endmodule

// File: rtl/refclk_prediv.sv
module refclk_prediv
  import prediv_pkg::*;
#(
  parameter int NUM_REFS = 4,
  parameter int N_MAX    = 12499,
  localparam int SEL_W   = (NUM_REFS > 1) ? $clog2(NUM_REFS) : 1,
  localparam int ADDR_W  = $clog2(NUM_REFS + 3),
  localparam int N_W     = $clog2(N_MAX + 1),
  localparam int RMAX    = ((N_MAX + 1) > int'(AUTO_RATIO_MAX)) ? (N_MAX + 1) : int'(AUTO_RATIO_MAX),
  localparam int RATIO_W = $clog2(RMAX + 1),
  localparam int SIG_W   = SEL_W + 2 + RATIO_W + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NUM_REFS-1:0] ref_i,
  input  logic [SEL_W-1:0]  ref_sel_i,
  input  logic              net_type_pin_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [7:0]        wr_data_i,
  output logic              cmp_strobe_o,
  output logic              edge_pol_o,
  output logic              unsupported_o,
  output logic              n_clamp_err_o
);

  logic [NUM_REFS-1:0]   rise, fall;
  logic [NUM_REFS*8-1:0] cfg_flat;
  logic [N_W-1:0]        n_val;
  logic                  falling, sonet, clamp_err;
  logic                  sel_ok;
  logic [7:0]            cfg_sel;
  logic                  rise_sel, fall_sel, edge_ev;
  prediv_mode_e          mode;
  logic [RATIO_W-1:0]    ratio;
  logic                  unsup_c, unsup_q;
  logic [SIG_W-1:0]      sig;

  generate
    for (genvar g = 0; g < NUM_REFS; g++) begin : g_sync
      prediv_sync_edge u_sync (
        .clk       (clk),
        .rst       (rst),
        .ref_async (ref_i[g]),
        .rise_o    (rise[g]),
        .fall_o    (fall[g])
      );
    end
  endgenerate

  prediv_cfg_regs #(.NUM_REFS(NUM_REFS), .N_MAX(N_MAX)) u_cfg (
    .clk            (clk),
    .rst            (rst),
    .net_type_pin_i (net_type_pin_i),
    .wr_en_i        (wr_en_i),
    .wr_addr_i      (wr_addr_i),
    .wr_data_i      (wr_data_i),
    .cfg_flat_o     (cfg_flat),
    .n_o            (n_val),
    .falling_o      (falling),
    .sonet_o        (sonet),
    .clamp_err_o    (clamp_err)
  );

  assign sel_ok = (int'(ref_sel_i) < NUM_REFS);

  always_comb begin
    cfg_sel  = 8'h00;
    rise_sel = 1'b0;
    fall_sel = 1'b0;
    for (int i = 0; i < NUM_REFS; i++) begin
      if (sel_ok && int'(ref_sel_i) == i) begin
        cfg_sel  = cfg_flat[i*8 +: 8];
        rise_sel = rise[i];
        fall_sel = fall[i];
      end
    end
  end

  assign edge_ev = sel_ok & (falling ? fall_sel : rise_sel);

  prediv_ratio_sel #(.N_MAX(N_MAX)) u_ratio (
    .clk           (clk),
    .rst           (rst),
    .cfg_i         (cfg_sel),
    .n_i           (n_val),
    .sonet_i       (sonet),
    .mode_o        (mode),
    .ratio_o       (ratio),
    .unsupported_o (unsup_c)
  );

  assign sig = {ref_sel_i, mode, ratio, falling};

  prediv_counter #(.RATIO_W(RATIO_W), .SIG_W(SIG_W)) u_cnt (
    .clk      (clk),
    .rst      (rst),
    .event_i  (edge_ev),
    .ratio_i  (ratio),
    .sig_i    (sig),
    .strobe_o (cmp_strobe_o)
  );

  always_ff @(posedge clk) begin
    if (rst) unsup_q <= 1'b0;
    else     unsup_q <= unsup_c & sel_ok;
  end

  assign unsupported_o = unsup_q;
  assign edge_pol_o    = falling;
  assign n_clamp_err_o = clamp_err;

  // R1: an out-of-range select never yields a strobe
  assert_no_strobe_bad_sel_R1: assert property (@(posedge clk) disable iff (rst)
    (!sel_ok && $past(!sel_ok)) |=> !cmp_strobe_o);

endmodule

// File: tb/test_refclk_prediv.sv
module test_refclk_prediv;

  localparam int NREF   = 3;
  localparam int NMAX   = 99;
  localparam int SEL_W  = 2;
  localparam int ADDR_W = $clog2(NREF + 3);
  localparam int A_NLO  = NREF;
  localparam int A_NHI  = NREF + 1;
  localparam int A_CTRL = NREF + 2;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic [NREF-1:0]   ref_i = '0;
  logic [SEL_W-1:0]  ref_sel = '0;
  logic              net_pin = 1'b1;
  logic              wr_en = 1'b0;
  logic [ADDR_W-1:0] wr_addr = '0;
  logic [7:0]        wr_data = '0;
  logic              strobe, pol, unsup, err;

  refclk_prediv #(.NUM_REFS(NREF), .N_MAX(NMAX)) i_refclk_prediv (
    .clk            (clk),
    .rst            (rst),
    .ref_i          (ref_i),
    .ref_sel_i      (ref_sel),
    .net_type_pin_i (net_pin),
    .wr_en_i        (wr_en),
    .wr_addr_i      (wr_addr),
    .wr_data_i      (wr_data),
    .cmp_strobe_o   (strobe),
    .edge_pol_o     (pol),
    .unsupported_o  (unsup),
    .n_clamp_err_o  (err)
  );

  always #4 clk = ~clk;

  int    n_checks = 0;
  int    n_fail   = 0;
  int    edge_no  = 0;
  int    mcnt     = 0;
  int    ratio_m  = 1;
  bit    pol_m    = 1'b0;
  string cur_req  = "R9";
  int    exp_q[$];
  bit    prev_strobe = 1'b0;
  bit    done = 1'b0;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int expv);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
    end
  endtask

  task automatic wr(input int a, input int d);
    @(negedge clk);
    wr_en   = 1'b1;
    wr_addr = ADDR_W'(a);
    wr_data = 8'(d);
    @(negedge clk);
    wr_en = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic phase(input int ratio, input string req);
    repeat (6) @(negedge clk);
    ratio_m = ratio;
    mcnt    = 0;
    edge_no = 0;
    cur_req = req;
  endtask

  task automatic end_phase();
    repeat (12) @(negedge clk);
    check(exp_q.size() == 0, cur_req, "missing strobes", exp_q.size(), 0);
    exp_q.delete();
  endtask

  task automatic edge_seen(input bit rising);
    if (rising == pol_m) return;
    edge_no++;
    if (mcnt == ratio_m - 1) begin
      exp_q.push_back(edge_no);
      mcnt = 0;
    end else begin
      mcnt++;
    end
  endtask

  // one reference period: 4 cycles high then 4 low
  task automatic pulses(input int idx, input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      ref_i[idx] = 1'b1;
      edge_seen(1'b1);
      repeat (4) @(negedge clk);
      ref_i[idx] = 1'b0;
      edge_seen(1'b0);
      repeat (3) @(negedge clk);
    end
  endtask

  // monitor: pops expected edge indices as strobes appear
  always @(negedge clk) begin
    if (!rst && !done) begin
      if (strobe) begin
        if (prev_strobe)
          check(1'b0, "R10", "strobe longer than one cycle", 2, 1);
        if (exp_q.size() == 0) begin
          check(1'b0, cur_req, "unexpected strobe at edge", edge_no, 0);
        end else begin
          int e;
          e = exp_q.pop_front();
          check(e == edge_no, cur_req, "strobe edge index", edge_no, e);
        end
      end
      prev_strobe = strobe;
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      check(1'b0, "WDOG", "watchdog expired", 0, 1);
      done = 1'b1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R9 reset state
    check(strobe == 1'b0, "R9", "strobe after reset", strobe, 0);
    check(pol == 1'b0,    "R9", "edge_pol after reset", pol, 0);
    check(unsup == 1'b0,  "R9", "unsupported after reset", unsup, 0);
    check(err == 1'b0,    "R9", "clamp err after reset", err, 0);

    // R1 pass-through on reference 0 (reset config)
    ref_sel = 2'd0;
    phase(1, "R1");
    pulses(0, 5);
    end_phase();

    // R2 automatic, code 1 gives ratio 8
    wr(1, 8'h41);
    ref_sel = 2'd1;
    phase(8, "R2");
    pulses(1, 16);
    end_phase();

    // R2/R7 code 2 with network type from pin = 1 gives 193
    wr(1, 8'h42);
    phase(193, "R7");
    pulses(1, 193);
    end_phase();

    // R2 network type cleared through control gives 256
    wr(A_CTRL, 8'h00);
    phase(256, "R2");
    pulses(1, 256);
    end_phase();

    // R5 unsupported code falls back to pass-through
    wr(2, 8'h49);
    ref_sel = 2'd2;
    phase(1, "R5");
    check(unsup == 1'b1, "R5", "unsupported flag", unsup, 1);
    pulses(2, 3);
    end_phase();

    // R3 manual N = 4 on reference 0
    wr(A_NLO, 4);
    wr(A_NHI, 0);
    wr(0, 8'h80);
    ref_sel = 2'd0;
    phase(5, "R3");
    check(unsup == 1'b0, "R5", "unsupported clear in pass/manual", unsup, 0);
    pulses(0, 10);
    end_phase();

    // R3 manual wins over automatic, shared N, on reference 2
    wr(2, 8'hC9);
    ref_sel = 2'd2;
    phase(5, "R3");
    check(unsup == 1'b0, "R3", "manual priority clears unsupported", unsup, 0);
    pulses(2, 5);
    end_phase();

    // R8 restart: partial count then change N to 6
    ref_sel = 2'd0;
    phase(5, "R8");
    pulses(0, 3);
    end_phase();
    wr(A_NLO, 6);
    wr(A_NHI, 0);
    phase(7, "R8");
    pulses(0, 7);
    end_phase();

    // R6 falling edge
    wr(A_CTRL, 8'h01);
    pol_m = 1'b1;
    phase(7, "R6");
    check(pol == 1'b1, "R6", "edge_pol reports falling", pol, 1);
    pulses(0, 7);
    end_phase();
    wr(A_CTRL, 8'h00);
    pol_m = 1'b0;

    // R4 lower clamp: N = 0 becomes 1
    check(err == 1'b0, "R4", "no clamp yet", err, 0);
    wr(A_NLO, 0);
    wr(A_NHI, 0);
    phase(2, "R4");
    check(err == 1'b1, "R4", "clamp flag after N=0", err, 1);
    pulses(0, 4);
    end_phase();

    // R4 upper clamp: N = 200 becomes 99, flag stays set
    wr(A_NLO, 200);
    wr(A_NHI, 0);
    phase(100, "R4");
    pulses(0, 100);
    end_phase();
    wr(A_NLO, 10);
    wr(A_NHI, 0);
    check(err == 1'b1, "R4", "clamp flag sticky after legal write", err, 1);

    // R1 out-of-range select: no strobes
    ref_sel = 2'd3;
    phase(1000000, "R1");
    pulses(0, 5);
    end_phase();

    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule